// File: doc/BRIEF.md
# USB Serial Receive Path

This block turns sampled USB line levels into received bytes. A front end that sits outside the block delivers a slice of up to eight DP/DM level pairs on each parallel clock, in arrival order, with lane 0 the oldest. The block looks for the SYNC pattern in those levels and then starts a packet. It recovers data bits from level transitions, drops inserted stuff bits and shifts the data bits into bytes. Each completed byte is presented on a UTMI-style receive interface. A line-state code reports the raw DP/DM levels.

At high speed all eight lanes of a slice carry bits. At full and low speed one bit arrives at a time on lane 0, and slices may have idle gaps between them. One operating mode skips transition decoding and unstuffing, so raw line levels are packed straight into bytes.

Top module: `usb_rx_path`

## Requirements
- R1: While `rst` is high on a clock edge, `rx_valid`, `rx_active` and `rx_error` are 0 after that edge, and `line_state` is 2'b00.
- R2: One clock after a slice with `slice_vld` high, `line_state` equals {DM, DP} of the last used lane (lane 7 at high speed, lane 0 otherwise). Read as {DM, DP}, 00 is SE0, 01 is J at high/full speed, 10 is K at high/full speed, and 11 is SE1.
- R3: `xcvr_sel` 2'b00 selects high speed, 2'b01 full speed, and 2'b1x low speed. J is DP high at high and full speed, and DM high at low speed. While idle, `rx_active` rises once the last eight levels read K J K J K J K K.
- R4: After SYNC the previous level is taken as K. Each following level gives a data bit of 1 if it equals the previous level, and 0 if it differs.
- R5: The count of consecutive 1s starts at 0 after SYNC. The bit that follows six consecutive 1s is dropped. If that dropped bit is a 1, `rx_error` pulses high for one clock.
- R6: Data bits fill each byte least-significant bit first. `rx_valid` is high for exactly one clock per completed byte, with that byte on `rx_data`, and the bytes come out in order with none lost and none added.
- R7: An SE0 level (DP and DM both low) during a packet clears `rx_active` and discards any partly filled byte.
- R8: With `opmode` 2'b10, each level after SYNC is a data bit directly (J = 1, K = 0). No bit is dropped, and `rx_error` stays low.
- R9: At high speed, all eight lanes are processed in order from lane 0. At full and low speed only lane 0 is processed. A slice with `slice_vld` low changes no output and no state.
- R10: A byte, an error or an `rx_active` change caused by a slice appears on the outputs exactly one clock after that slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock (60 MHz domain) |
| rst | input | 1 | Synchronous active-high reset |
| slice_vld | input | 1 | Slice of line levels is present |
| line_dp | input | 8 | DP level per lane, lane 0 oldest |
| line_dm | input | 8 | DM level per lane, lane 0 oldest |
| opmode | input | 2 | 2'b10 bypasses decoding and unstuffing |
| xcvr_sel | input | 2 | Speed: 00 high, 01 full, 1x low |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-clock strobe for `rx_data` |
| rx_active | output | 1 | Packet in progress |
| rx_error | output | 1 | Stuff error strobe |
| line_state | output | 2 | Registered {DM, DP} of the last used lane |

## Verification
Every result of a slice is registered once, so bytes, error strobes, the activity flag and the line state all become visible one clock after the slice is driven. The bench drives inputs on the falling edge and samples on the next falling edge, which falls exactly one rising edge after the slice. A monitor compares each `rx_valid` strobe in that window against a queue of expected bytes. Directed checks read `rx_active`, `line_state` and a single-byte strobe in the cycle just after the slice that causes them.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SYNC_LEN  = 8;
  localparam int unsigned STUFF_RUN = 6;
  localparam int unsigned CNT_W     = $clog2(BYTE_W);
  localparam int unsigned RUN_W     = $clog2(STUFF_RUN + 1);

  // K flags of the SYNC pattern, oldest symbol in the MSB
  localparam logic [SYNC_LEN-1:0] SYNC_K = 8'b1010_1011;

  localparam logic [1:0] MODE_RAW = 2'b10;
  localparam logic [1:0] SPD_HS   = 2'b00;

  typedef struct packed {
    logic                active;
    logic                prev_k;
    logic [RUN_W-1:0]    run;
    logic [SYNC_LEN-1:0] hist;
    logic [BYTE_W-1:0]   shreg;
    logic [CNT_W-1:0]    cnt;
  } rx_st_t;
endpackage

// File: rtl/usb_rx_lane.sv
module usb_rx_lane
  import usb_rx_pkg::*;
(
  input  rx_st_t st_i,
  input  logic   en,
  input  logic   dp,
  input  logic   dm,
  input  logic   bypass,
  input  logic   low_spd,
  output rx_st_t st_o,
  output logic   done,
  output logic   err
);
  logic is_k, se0, bit_d;
  logic [SYNC_LEN-1:0] hist_n;

  assign is_k   = low_spd ? dp : ~dp;
  assign se0    = ~dp & ~dm;
  assign hist_n = {st_i.hist[SYNC_LEN-2:0], is_k};

  always_comb begin
    st_o  = st_i;
    done  = 1'b0;
    err   = 1'b0;
    bit_d = bypass ? ~is_k : (is_k == st_i.prev_k);
    if (en) begin
      if (!st_i.active) begin
        if (se0) begin
          st_o.hist = '0;
        end else begin
          st_o.hist = hist_n;
          if (hist_n == SYNC_K) begin
            st_o.active = 1'b1;
            st_o.prev_k = 1'b1;
            st_o.run    = '0;
            st_o.cnt    = '0;
          end
        end
      end else if (se0) begin
        st_o.active = 1'b0;
        st_o.cnt    = '0;
        st_o.run    = '0;
        st_o.hist   = '0;
      end else begin
        st_o.prev_k = is_k;
        if (!bypass && st_i.run == RUN_W'(STUFF_RUN)) begin
          st_o.run = '0;
          err      = bit_d;
        end else begin
          st_o.run   = (bit_d && !bypass) ? st_i.run + 1'b1 : '0;
          st_o.shreg = {bit_d, st_i.shreg[BYTE_W-1:1]};
          st_o.cnt   = st_i.cnt + 1'b1;
          done       = (st_i.cnt == CNT_W'(BYTE_W - 1));
        end
      end
    end
  end
endmodule

// File: rtl/usb_rx_linestate.sv
module usb_rx_linestate #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slice_vld,
  input  logic             high_spd,
  input  logic [LANES-1:0] line_dp,
  input  logic [LANES-1:0] line_dm,
  output logic [1:0]       line_state
);
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = high_spd ? IDX_W'(LANES - 1) : '0;

  always_ff @(posedge clk) begin
    if (rst)            line_state <= 2'b00;
    else if (slice_vld) line_state <= {line_dm[last_idx], line_dp[last_idx]};
  end
endmodule

// File: rtl/usb_rx_path.sv
module usb_rx_path
  import usb_rx_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slice_vld,
  input  logic [LANES-1:0]  line_dp,
  input  logic [LANES-1:0]  line_dm,
  input  logic [1:0]        opmode,
  input  logic [1:0]        xcvr_sel,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [1:0]        line_state
);
  logic high_spd, bypass, low_spd;
  rx_st_t state_q;
  rx_st_t chain [LANES+1];
  logic [LANES-1:0] lane_done, lane_err, lane_en;
  logic              any_done;
  logic [BYTE_W-1:0] byte_n;

  assign high_spd = (xcvr_sel == SPD_HS);
  assign low_spd  = xcvr_sel[1];
  assign bypass   = (opmode == MODE_RAW);
  assign chain[0] = state_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = slice_vld && (high_spd || i == 0);
    usb_rx_lane u_lane (
      .st_i    (chain[i]),
      .en      (lane_en[i]),
      .dp      (line_dp[i]),
      .dm      (line_dm[i]),
      .bypass  (bypass),
      .low_spd (low_spd),
      .st_o    (chain[i+1]),
      .done    (lane_done[i]),
      .err     (lane_err[i])
    );
  end

  always_comb begin
    any_done = 1'b0;
    byte_n   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_done[i]) begin
        any_done = 1'b1;
        byte_n   = chain[i+1].shreg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= '0;
      rx_valid <= 1'b0;
      rx_error <= 1'b0;
      rx_data  <= '0;
    end else begin
      state_q  <= chain[LANES];
      rx_valid <= any_done;
      rx_error <= |lane_err;
      if (any_done) rx_data <= byte_n;
    end
  end

  assign rx_active = state_q.active;

  usb_rx_linestate #(.LANES(LANES)) u_ls (
    .clk        (clk),
    .rst        (rst),
    .slice_vld  (slice_vld),
    .high_spd   (high_spd),
    .line_dp    (line_dp),
    .line_dm    (line_dm),
    .line_state (line_state)
  );
endmodule

// File: rtl/usb_rx_path_chk.sv
module usb_rx_path_chk #(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             slice_vld,
  input logic [LANES-1:0] line_dp,
  input logic [LANES-1:0] line_dm,
  input logic [1:0]       opmode,
  input logic [1:0]       xcvr_sel,
  input logic [7:0]       rx_data,
  input logic             rx_valid,
  input logic             rx_active,
  input logic             rx_error,
  input logic [1:0]       line_state
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_active && !rx_error && line_state == 2'b00));

  assert_lane0_state_R2: assert property (@(posedge clk) disable iff (rst)
    (slice_vld && xcvr_sel != 2'b00) |=> line_state == {$past(line_dm[0]), $past(line_dp[0])});

  assert_start_on_slice_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> $past(slice_vld));

  assert_raw_no_error_R8: assert property (@(posedge clk) disable iff (rst)
    (opmode == 2'b10) |=> !rx_error);

  assert_idle_slice_R9: assert property (@(posedge clk) disable iff (rst)
    !slice_vld |=> ($stable(line_state) && $stable(rx_active) && !rx_valid && !rx_error));

  assert_end_on_slice_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_active) |-> $past(slice_vld));
endmodule

bind usb_rx_path usb_rx_path_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slice_vld  (slice_vld),
  .line_dp    (line_dp),
  .line_dm    (line_dm),
  .opmode     (opmode),
  .xcvr_sel   (xcvr_sel),
  .rx_data    (rx_data),
  .rx_valid   (rx_valid),
  .rx_active  (rx_active),
  .rx_error   (rx_error),
  .line_state (line_state)
);

// File: tb/usb_rx_path_tb.sv
module usb_rx_path_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slice_vld = 1'b0;
  logic [7:0] line_dp = '0, line_dm = '0;
  logic [1:0] opmode = 2'b00, xcvr_sel = 2'b00;
  logic [7:0] rx_data;
  logic       rx_valid, rx_active, rx_error;
  logic [1:0] line_state;

  int total = 0, bad = 0, err_seen = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [1:0] lq[$];
  logic prev_k;
  int   run;

  always #5 clk = ~clk;

  usb_rx_path u_dut (
    .clk(clk), .rst(rst), .slice_vld(slice_vld), .line_dp(line_dp), .line_dm(line_dm),
    .opmode(opmode), .xcvr_sel(xcvr_sel), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_active(rx_active), .rx_error(rx_error), .line_state(line_state)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard for R6, error strobe counter for R5/R8
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (exp_q.size() == 0) check("R6 unexpected byte", rx_data, 8'hxx);
      else check("R6 byte", rx_data, exp_q.pop_front());
    end
    if (!rst && rx_error) err_seen++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {dm,dp} for a K (k=1) or J (k=0) at the current speed
  function automatic logic [1:0] lvl(input logic k);
    if (xcvr_sel[1]) return k ? 2'b01 : 2'b10;
    return k ? 2'b10 : 2'b01;
  endfunction

  task automatic start_pkt();
    repeat (3) lq.push_back(lvl(1'b0));
    for (int i = 0; i < 8; i++) lq.push_back(lvl((8'b1010_1011 >> (7 - i)) & 1'b1));
    prev_k = 1'b1;
    run = 0;
  endtask

  task automatic enc_bit(input logic b);
    if (opmode == 2'b10) begin
      lq.push_back(lvl(~b));
    end else begin
      if (!b) prev_k = ~prev_k;
      lq.push_back(lvl(prev_k));
      run = b ? run + 1 : 0;
      if (run == 6) begin
        prev_k = ~prev_k;
        lq.push_back(lvl(prev_k));
        run = 0;
      end
    end
  endtask

  task automatic enc_byte(input logic [7:0] v, input bit expect_it);
    for (int i = 0; i < 8; i++) enc_bit(v[i]);
    if (expect_it) exp_q.push_back(v);
  endtask

  task automatic end_pkt();
    lq.push_back(2'b00); lq.push_back(2'b00);
    lq.push_back(lvl(1'b0)); lq.push_back(lvl(1'b0));
  endtask

  task automatic feed(input int keep);
    while (lq.size() > keep) begin
      @(negedge clk);
      slice_vld = 1'b1;
      if (xcvr_sel == 2'b00) begin
        for (int i = 0; i < 8; i++) begin
          logic [1:0] v;
          v = (lq.size() > keep) ? lq.pop_front() : lvl(1'b0);
          line_dp[i] = v[0];
          line_dm[i] = v[1];
        end
      end else begin
        logic [1:0] v;
        v = lq.pop_front();
        line_dp = {7'h7f, v[0]};
        line_dm = {7'h7f, v[1]};
        @(negedge clk);   // idle gap carrying SE0 on every lane
        slice_vld = 1'b0;
        line_dp = '0;
        line_dm = '0;
      end
    end
    if (keep == 0) begin
      @(negedge clk);
      slice_vld = 1'b0;
      line_dp = '0;
      line_dm = '0;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    check("R1 rx_valid", {7'b0, rx_valid}, 8'h0);
    check("R1 rx_active", {7'b0, rx_active}, 8'h0);
    check("R1 rx_error", {7'b0, rx_error}, 8'h0);
    check("R1 line_state", {6'b0, line_state}, 8'h0);
    rst = 1'b0;

    // line state, full speed lane 0 then idle slice hold
    xcvr_sel = 2'b01;
    @(negedge clk); slice_vld = 1; line_dp = 8'h01; line_dm = 8'hfe;
    @(negedge clk); slice_vld = 0; line_dp = 8'hff; line_dm = 8'hff;
    check("R2 J code", {6'b0, line_state}, 8'h01);
    @(negedge clk);
    check("R9 idle slice holds line_state", {6'b0, line_state}, 8'h01);
    @(negedge clk); slice_vld = 1; line_dp = 8'h00; line_dm = 8'h01;
    @(negedge clk); slice_vld = 0;
    check("R2 K code", {6'b0, line_state}, 8'h02);
    xcvr_sel = 2'b00;
    @(negedge clk); slice_vld = 1; line_dp = 8'h7f; line_dm = 8'h80;
    @(negedge clk); slice_vld = 0;
    check("R2 high speed uses lane 7", {6'b0, line_state}, 8'h02);
    @(negedge clk); slice_vld = 1; line_dp = 8'h80; line_dm = 8'h80;
    @(negedge clk); slice_vld = 0; line_dp = '0; line_dm = '0;
    check("R2 SE1 code", {6'b0, line_state}, 8'h03);
    repeat (2) @(negedge clk);

    // high speed packet with runs of ones (R4 R5 R6 R9)
    e0 = err_seen;
    start_pkt();
    enc_byte(8'hA5, 1); enc_byte(8'hFF, 1); enc_byte(8'h3F, 1); enc_byte(8'h00, 1);
    enc_byte(8'h7E, 1); enc_byte(8'h81, 1); enc_byte(8'hFF, 1); enc_byte(8'hFF, 1);
    end_pkt();
    feed(0);
    check("R6 all HS bytes delivered", 8'(exp_q.size()), 8'h0);
    check("R5 no error on legal stuffing", 8'(err_seen - e0), 8'h0);
    check("R7 HS packet ended", {7'b0, rx_active}, 8'h0);

    // full speed with idle gaps (R3 R7 R9)
    xcvr_sel = 2'b01;
    start_pkt();
    feed(0);
    check("R3 active after SYNC", {7'b0, rx_active}, 8'h1);
    enc_byte(8'h5A, 1); enc_byte(8'hC0, 1);
    end_pkt();
    feed(0);
    check("R7 active cleared by SE0", {7'b0, rx_active}, 8'h0);
    check("R9 FS bytes delivered through gaps", 8'(exp_q.size()), 8'h0);

    // latency of a single byte (R10)
    start_pkt();
    enc_byte(8'h96, 1);
    feed(1);
    @(negedge clk); slice_vld = 1;
    line_dp = {7'h7f, lq[0][0]}; line_dm = {7'h7f, lq[0][1]};
    void'(lq.pop_front());
    @(negedge clk); slice_vld = 0; line_dp = '0; line_dm = '0;
    check("R10 valid one clock after last bit", {7'b0, rx_valid}, 8'h1);
    check("R10 data one clock after last bit", rx_data, 8'h96);
    end_pkt();
    feed(0);

    // low speed polarity (R3)
    xcvr_sel = 2'b10;
    start_pkt();
    enc_byte(8'hC3, 1); enc_byte(8'hFE, 1);
    end_pkt();
    feed(0);
    check("R3 LS bytes delivered", 8'(exp_q.size()), 8'h0);

    // partial byte dropped at EOP (R7)
    xcvr_sel = 2'b00;
    start_pkt();
    enc_byte(8'h12, 1);
    enc_bit(1'b1); enc_bit(1'b0); enc_bit(1'b1);
    end_pkt();
    feed(0);
    repeat (3) @(negedge clk);
    check("R7 partial byte discarded", 8'(exp_q.size()), 8'h0);

    // stuff error: seven unchanged levels after SYNC (R5)
    e0 = err_seen;
    start_pkt();
    repeat (7) lq.push_back(lvl(1'b1));
    end_pkt();
    feed(0);
    check("R5 stuff error strobes", 8'(err_seen - e0), 8'h1);

    // raw mode: no unstuffing, no error (R8)
    opmode = 2'b10;
    e0 = err_seen;
    start_pkt();
    enc_byte(8'hFF, 1); enc_byte(8'hFF, 1); enc_byte(8'h00, 1); enc_byte(8'h7E, 1);
    end_pkt();
    feed(0);
    check("R8 raw bytes delivered", 8'(exp_q.size()), 8'h0);
    check("R8 no error in raw mode", 8'(err_seen - e0), 8'h0);
    opmode = 2'b00;

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule